// File: doc/BRIEF.md
# Link and Activity Status LED Driver

This block drives three status LEDs from the traffic and link indications of an Ethernet port. Each LED has a 3-bit function code that picks what it shows: nothing, collision activity, inverted collision activity, a 10 Mb/s link, a 100 Mb/s link, either link, an automatic link-and-traffic display, or transmit activity. A separate enable bit per LED ORs stretched receive activity on top of the selected function. Two LEDs take their settings from one control byte. The third LED takes its settings from a second byte.

Collision, transmit and receive indications arrive as single-cycle pulses. Each source passes through its own stretcher, a two-state machine with states `SX_IDLE` and `SX_HOLD`. A pulse moves the machine from `SX_IDLE` to `SX_HOLD` (transition *arm*). A pulse in `SX_HOLD` reloads the down-counter (transition *retrigger*). The machine returns to `SX_IDLE` when the counter has run out with no new pulse (transition *expire*). The hold time is set by the `stretch_len` input. Each LED output is a register, and the outputs are active-high.

Top module: `led_status_driver`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after release with no activity, all of `led_out` is 0 and every stretcher is in `SX_IDLE`.
- R2: Function code 000 keeps its LED at 0, even when a link is up. Only the receive-add bit can light that LED.
- R3: Code 001 shows stretched collision activity. Code 010 shows its inverse, so the LED is 1 when there is no collision activity.
- R4: Code 011 shows `link10`. Code 100 shows `link100`. Code 101 shows `link10 | link100`.
- R5: Code 110 (automatic) shows `link10 | link100`, but is 0 while stretched transmit or receive activity is present.
- R6: Code 111 shows stretched transmit activity.
- R7: A pulse sampled at clock edge k makes the stretched activity true after edge k. The activity stays true for exactly `stretch_len`+1 cycles after the last pulse. A pulse while the activity is already true restarts the full hold. With `stretch_len`=0 the stretch lasts one cycle.
- R8: Receive-add bits: `led_ctrl_a[6]` serves LED0, `led_ctrl_a[7]` serves LED1, and `led_ctrl_b[6]` serves LED2. When a bit is set, stretched receive activity is ORed onto that LED. Bits 7 and 5:3 of `led_ctrl_b` have no effect.
- R9: Function codes come from `led_ctrl_a[2:0]` for LED0 (`led_out[0]`), from `led_ctrl_a[5:3]` for LED1 (`led_out[1]`), and from `led_ctrl_b[2:0]` for LED2 (`led_out[2]`).
- R10: Level inputs (link levels and control bytes) reach `led_out` at the first clock edge after they change. A pulse lights an LED at the second edge, counting the edge that samples the pulse as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| led_ctrl_a | input | 8 | Function codes and receive-add bits for LED0 and LED1 |
| led_ctrl_b | input | 8 | Function code and receive-add bit for LED2 |
| stretch_len | input | CNT_W | Extra hold cycles after the last activity pulse |
| col_pulse | input | 1 | Collision event pulse |
| tx_pulse | input | 1 | Transmit event pulse |
| rx_pulse | input | 1 | Receive event pulse |
| link10 | input | 1 | 10 Mb/s link-detected level |
| link100 | input | 1 | 100 Mb/s link-detected level |
| led_out | output | 3 | Registered LED drives, bit n is LED n |

## Verification
A stretcher stuck in `SX_HOLD`, or a counter that reloads badly, shows at the ports as an LED whose lit window is too long or too short. The error appears within `stretch_len`+2 cycles of a pulse. This is why the bench checks the exact edge where each lit window starts and ends, including a retrigger in the middle of a hold and a hold length of zero.

A wrong decode of the function code or of the field position shows at the first edge after the control bytes change. The bench sets a different code on each LED at the same time so that a swapped field is caught. The ignored control bits are checked by setting them while receive activity runs.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    typedef enum logic [2:0] {
        FN_OFF     = 3'b000,
        FN_COL     = 3'b001,
        FN_NCOL    = 3'b010,
        FN_LINK10  = 3'b011,
        FN_LINK100 = 3'b100,
        FN_LINKANY = 3'b101,
        FN_AUTO    = 3'b110,
        FN_TX      = 3'b111
    } led_func_e;

    typedef enum logic {
        SX_IDLE = 1'b0,
        SX_HOLD = 1'b1
    } stretch_state_e;

    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned SRC_COL  = 0;
    localparam int unsigned SRC_TX   = 1;
    localparam int unsigned SRC_RX   = 2;

endpackage

// File: rtl/act_stretch.sv
module act_stretch
    import led_drv_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o
);

    stretch_state_e   state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state: arm, retrigger, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SX_IDLE: begin
                if (pulse_i) begin
                    state_d = SX_HOLD;
                    cnt_d   = len_i;
                end
            end
            SX_HOLD: begin
                if (pulse_i) begin
                    cnt_d = len_i;
                end else if (cnt_q == '0) begin
                    state_d = SX_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = SX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active_o = (state_q == SX_HOLD);
    end

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (state_q == SX_HOLD) && (cnt_q == $past(len_i)));

    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SX_HOLD && cnt_q == '0 && !pulse_i) |=> (state_q == SX_IDLE));

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SX_IDLE && !pulse_i) |=> (state_q == SX_IDLE));

endmodule

// File: rtl/led_lane.sv
module led_lane
    import led_drv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] func_i,
    input  logic       rx_add_i,
    input  logic       col_act_i,
    input  logic       tx_act_i,
    input  logic       rx_act_i,
    input  logic       link10_i,
    input  logic       link100_i,
    output logic       led_o
);

    led_func_e func;
    logic      any_link;
    logic      base_d;
    logic      led_d;

    always_comb begin
        func     = led_func_e'(func_i);
        any_link = link10_i | link100_i;
        unique case (func)
            FN_OFF:     base_d = 1'b0;
            FN_COL:     base_d = col_act_i;
            FN_NCOL:    base_d = ~col_act_i;
            FN_LINK10:  base_d = link10_i;
            FN_LINK100: base_d = link100_i;
            FN_LINKANY: base_d = any_link;
            FN_AUTO:    base_d = any_link & ~(tx_act_i | rx_act_i);
            FN_TX:      base_d = tx_act_i;
            default:    base_d = 1'b0;
        endcase
        led_d = base_d | (rx_add_i & rx_act_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led_o <= 1'b0;
        else        led_o <= led_d;
    end

    assert_off_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 3'b000 && !rx_add_i) |=> !led_o);

    assert_tx_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 3'b111 && !rx_add_i) |=> (led_o == $past(tx_act_i)));

    assert_rx_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_add_i && rx_act_i) |=> led_o);

endmodule

// File: rtl/led_status_driver.sv
module led_status_driver
    import led_drv_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       led_ctrl_a,
    input  logic [7:0]       led_ctrl_b,
    input  logic [CNT_W-1:0] stretch_len,
    input  logic             col_pulse,
    input  logic             tx_pulse,
    input  logic             rx_pulse,
    input  logic             link10,
    input  logic             link100,
    output logic [2:0]       led_out
);

    localparam int unsigned NUM_LEDS = 3;

    logic [NUM_SRC-1:0]  src_pulse;
    logic [NUM_SRC-1:0]  src_act;
    logic [2:0]          lane_func [NUM_LEDS];
    logic [NUM_LEDS-1:0] lane_rx_add;
    logic                unused_ctrl_bits;

    always_comb begin
        src_pulse[SRC_COL] = col_pulse;
        src_pulse[SRC_TX]  = tx_pulse;
        src_pulse[SRC_RX]  = rx_pulse;
        lane_func[0]       = led_ctrl_a[2:0];
        lane_func[1]       = led_ctrl_a[5:3];
        lane_func[2]       = led_ctrl_b[2:0];
        lane_rx_add        = {led_ctrl_b[6], led_ctrl_a[7], led_ctrl_a[6]};
        unused_ctrl_bits   = ^{led_ctrl_b[7], led_ctrl_b[5:3]};
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        act_stretch #(.CNT_W(CNT_W)) u_stretch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pulse_i  (src_pulse[s]),
            .len_i    (stretch_len),
            .active_o (src_act[s])
        );
    end

    for (genvar n = 0; n < NUM_LEDS; n++) begin : g_lane
        led_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .func_i    (lane_func[n]),
            .rx_add_i  (lane_rx_add[n]),
            .col_act_i (src_act[SRC_COL]),
            .tx_act_i  (src_act[SRC_TX]),
            .rx_act_i  (src_act[SRC_RX]),
            .link10_i  (link10),
            .link100_i (link100),
            .led_o     (led_out[n])
        );
    end

    assert_link_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (led_ctrl_a[2:0] == 3'b011 && !led_ctrl_a[6]) |=> (led_out[0] == $past(link10)));

endmodule

// File: tb/led_status_driver_bench.sv
module led_status_driver_bench;

    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       led_ctrl_a = '0;
    logic [7:0]       led_ctrl_b = '0;
    logic [CNT_W-1:0] stretch_len = '0;
    logic             col_pulse = 1'b0;
    logic             tx_pulse = 1'b0;
    logic             rx_pulse = 1'b0;
    logic             link10 = 1'b0;
    logic             link100 = 1'b0;
    logic [2:0]       led_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    led_status_driver #(.CNT_W(CNT_W)) u_led_status_driver (
        .clk         (clk),
        .rst_n       (rst_n),
        .led_ctrl_a  (led_ctrl_a),
        .led_ctrl_b  (led_ctrl_b),
        .stretch_len (stretch_len),
        .col_pulse   (col_pulse),
        .tx_pulse    (tx_pulse),
        .rx_pulse    (rx_pulse),
        .link10      (link10),
        .link100     (link100),
        .led_out     (led_out)
    );

    // monitor: compares 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (led_out !== it.exp) begin
                errors++;
                $display("FAIL %s: led_out=%b expected=%b at %0t", it.tag, led_out, it.exp, $time);
            end
        end
    end

    // driver: inputs already set at this negedge; expect value after next edge
    task automatic step(input logic [2:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        col_pulse = 1'b0;
        tx_pulse  = 1'b0;
        rx_pulse  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        #12;
        checks++;
        if (led_out !== 3'b000) begin
            errors++;
            $display("FAIL R1: led_out=%b expected=000 in reset", led_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(3'b000, "R1 after release");

        // R2: code 000 dark with links up
        link10 = 1'b1; link100 = 1'b1;
        step(3'b000, "R2 off with link");

        // R9 + R4: LED0 code 011, LED1 code 100, LED2 code 101
        led_ctrl_a = 8'b00_100_011; led_ctrl_b = 8'h05;
        link10 = 1'b1; link100 = 1'b0;
        step(3'b101, "R4 R9 R10 link10 only");
        link10 = 1'b0; link100 = 1'b1;
        step(3'b110, "R4 R9 link100 only");
        link10 = 1'b0; link100 = 1'b0;
        step(3'b000, "R4 no link");

        // R3 + R7: LED0 code 001, LED1 code 010, stretch 3
        stretch_len = 8'd3;
        led_ctrl_a = 8'b00_010_001; led_ctrl_b = 8'h00;
        step(3'b010, "R3 idle collision");
        col_pulse = 1'b1;
        step(3'b010, "R10 pulse edge");
        step(3'b001, "R3 R7 lit 1");
        step(3'b001, "R7 lit 2");
        step(3'b001, "R7 lit 3");
        step(3'b001, "R7 lit 4");
        step(3'b010, "R7 expired");

        // R7 retrigger
        col_pulse = 1'b1;
        step(3'b010, "R7 rt pulse");
        step(3'b001, "R7 rt lit a");
        col_pulse = 1'b1;
        step(3'b001, "R7 rt lit b");
        step(3'b001, "R7 rt lit c");
        step(3'b001, "R7 rt lit d");
        step(3'b001, "R7 rt lit e");
        step(3'b001, "R7 rt lit f");
        step(3'b010, "R7 rt expired");

        // R6 + R7: LED2 code 111, stretch 0
        led_ctrl_a = 8'h00; led_ctrl_b = 8'h07; stretch_len = 8'd0;
        step(3'b000, "R6 idle");
        tx_pulse = 1'b1;
        step(3'b000, "R6 pulse edge");
        step(3'b100, "R6 R7 zero-len lit");
        step(3'b000, "R6 R7 zero-len over");

        // R8: receive-add bits, code 000 everywhere
        stretch_len = 8'd2;
        led_ctrl_a = 8'hC0; led_ctrl_b = 8'h40;
        step(3'b000, "R8 idle");
        rx_pulse = 1'b1;
        step(3'b000, "R8 pulse edge");
        step(3'b111, "R8 rx lit 1");
        step(3'b111, "R8 rx lit 2");
        step(3'b111, "R8 rx lit 3");
        step(3'b000, "R8 rx over");

        // R8: ignored bits of led_ctrl_b and cleared add bits
        led_ctrl_a = 8'h00; led_ctrl_b = 8'hB8;
        step(3'b000, "R8 ignored idle");
        rx_pulse = 1'b1;
        step(3'b000, "R8 ignored pulse");
        step(3'b000, "R8 ignored bits no effect 1");
        step(3'b000, "R8 ignored bits no effect 2");
        idle(3);

        // R5: automatic mode on LED2
        led_ctrl_b = 8'h06; link10 = 1'b1; stretch_len = 8'd3;
        step(3'b100, "R5 link shown");
        tx_pulse = 1'b1;
        step(3'b100, "R5 pulse edge");
        step(3'b000, "R5 dark 1");
        step(3'b000, "R5 dark 2");
        step(3'b000, "R5 dark 3");
        step(3'b000, "R5 dark 4");
        step(3'b100, "R5 back on");
        link10 = 1'b0;
        step(3'b000, "R5 no link");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
        end
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule